// File: doc/BRIEF.md
# Predicate Lane Count Scan

This block reduces a 64-lane byte vector, or a 64-bit predicate mask, to one scalar count in a single pass. It offers a population count of the mask and a bit count of each byte. It also counts lanes that meet a comparison, either `a == b` or `a <= b`. Each comparison has a form against zero and can be gated by the mask. Lane comparison, gating and a shared adder tree all sit between the inputs and one result register.

A caller presents the operands together with an operation code and raises `start` for one cycle. On the next cycle the block raises `valid_o` for one cycle. It holds the scalar count and the packed vector of per-byte counts until the next `start`. Writing the result back to a register file is left to the surrounding logic.

Top module: `lane_count_scan`

## Requirements
- R1: With `op_sel` = 0, the scalar count equals the number of set bits in `gate_mask`. The value lies in 0 to 64 and is zero-extended to 32 bits.
- R2: With `op_sel` = 1, field i of `lane_cnt_o` (bits [4i+3:4i]) holds the number of set bits in byte i of `vec_a`, a value from 0 to 8. The scalar count is 0.
- R3: With `op_sel` = 2, the count is the number of lanes i where byte i of `vec_a` equals byte i of `vec_b`. Lane i occupies bits [8i+7:8i].
- R4: With `op_sel` = 3, the count is the number of lanes where the byte of `vec_a` is zero. `vec_b` has no effect.
- R5: With `op_sel` = 4, the count is the number of lanes where byte a <= byte b, with both bytes compared as unsigned values.
- R6: With `op_sel` = 5, the count is the number of lanes where byte a <= 0 unsigned, which is the same as a == 0. `vec_b` has no effect.
- R7: When `gate_en` = 1, operations 2 to 5 count lane i only if bit i of `gate_mask` is set. `gate_en` has no effect on operations 0 and 1.
- R8: `valid_o` is high in the cycle after `start` and only then. Both outputs hold their values until the next `start`.
- R9: `lane_cnt_o` is zero for every operation except 1. Operation codes 6 and 7 give a count of 0 and a zero lane vector.
- R10: After a synchronous reset (`rst_n` low), `valid_o` is 0, the count is 0 and `lane_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that starts an operation |
| op_sel | input | 3 | Operation code: 0 mask popcount, 1 byte count, 2 eq, 3 eq-zero, 4 le, 5 le-zero |
| gate_en | input | 1 | Applies `gate_mask` to the compare operations |
| vec_a | input | 512 | First byte vector |
| vec_b | input | 512 | Second byte vector |
| gate_mask | input | 64 | Predicate mask: popcount operand, or lane gate |
| valid_o | output | 1 | Result strobe, one cycle |
| count_o | output | 32 | Scalar count, zero-extended |
| lane_cnt_o | output | 256 | Packed 4-bit per-byte bit counts |

## Verification
Every result is due exactly one clock after the `start` that launched it. The bench raises `start` on a falling edge and lets the next rising edge capture the result. It reads `valid_o`, `count_o` and `lane_cnt_o` on the falling edge that follows, then checks one falling edge later that `valid_o` has dropped. For the hold behaviour, the bench changes the operands without `start`, waits two cycles and expects the outputs to be unchanged.

// File: rtl/lcs_pkg.sv
// Package: shared operation codes for the lane count scan.
// Assumes a 3-bit operation select; codes 6 and 7 are unused.
package lcs_pkg;
    typedef enum logic [2:0] {
        OP_POPM = 3'd0,
        OP_BYTE = 3'd1,
        OP_EQ   = 3'd2,
        OP_EQZ  = 3'd3,
        OP_LE   = 3'd4,
        OP_LEZ  = 3'd5
    } lcs_op_e;
endpackage

// File: rtl/lcs_lane_array.sv
// Module: per-lane comparators and byte bit counters.
// Each lane is compared unsigned. Lane g takes bits [g*LANE_W +: LANE_W]
// of each vector. Each byte count is truncated to FIELD_W bits.
module lcs_lane_array #(
    parameter int LANES   = 64,
    parameter int LANE_W  = 8,
    parameter int FIELD_W = 4
) (
    input  logic [LANES*LANE_W-1:0]  a_vec,
    input  logic [LANES*LANE_W-1:0]  b_vec,
    output logic [LANES-1:0]         eq_hit,
    output logic [LANES-1:0]         le_hit,
    output logic [LANES-1:0]         zero_hit,
    output logic [LANES*FIELD_W-1:0] byte_cnt
);
    localparam int BC_W = $clog2(LANE_W + 1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] a_b;
        logic [LANE_W-1:0] b_b;
        logic [BC_W-1:0]   ones;

        assign a_b = a_vec[g*LANE_W +: LANE_W];
        assign b_b = b_vec[g*LANE_W +: LANE_W];

        // Lane predicates: equality, unsigned less-or-equal, and zero test.
        assign eq_hit[g]   = (a_b == b_b);
        assign le_hit[g]   = (a_b <= b_b);
        assign zero_hit[g] = (a_b == '0);

        // Count the set bits of this lane's byte from vec_a.
        always_comb begin
            ones = '0;
            for (int k = 0; k < LANE_W; k++) begin
                ones = ones + BC_W'(a_b[k]);
            end
        end

        // Truncate the count to the packed field width.
        assign byte_cnt[g*FIELD_W +: FIELD_W] = FIELD_W'(ones);
    end
endmodule

// File: rtl/lcs_popcount.sv
// Module: binary adder tree that counts the set bits of an N-bit word.
// Assumes N is a power of two. The nodes form a heap: node 0 is the root,
// and the leaves sit at N-1 .. 2N-2.
module lcs_popcount #(
    parameter int N  = 64,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] total_o
);
    localparam int NODES = 2 * N - 1;

    logic [CW-1:0] node [NODES];

    // Leaves: widen each input bit to the count width.
    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N - 1 + i] = CW'(bits_i[i]);
    end

    // Internal nodes: each one adds its two children.
    for (genvar k = 0; k < N - 1; k++) begin : g_sum
        assign node[k] = node[2*k + 1] + node[2*k + 2];
    end

    assign total_o = node[0];
endmodule

// File: rtl/lane_count_scan.sv
// Module: top of the lane count scan. It chooses the operand of the shared
// adder tree from the operation code and the gate, and registers the count
// and the per-byte counts on start. valid_o pulses one cycle after start.
// Assumes start lasts one cycle and that LANES is a power of two.
module lane_count_scan
    import lcs_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int LANE_W  = 8,
    parameter int FIELD_W = 4,
    parameter int OUT_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [2:0]                op_sel,
    input  logic                      gate_en,
    input  logic [LANES*LANE_W-1:0]   vec_a,
    input  logic [LANES*LANE_W-1:0]   vec_b,
    input  logic [LANES-1:0]          gate_mask,
    output logic                      valid_o,
    output logic [OUT_W-1:0]          count_o,
    output logic [LANES*FIELD_W-1:0]  lane_cnt_o
);
    localparam int CNT_W = $clog2(LANES + 1);
    localparam int FLD_V = LANES * FIELD_W;

    lcs_op_e            op;
    logic [LANES-1:0]   eq_hit, le_hit, zero_hit;
    logic [FLD_V-1:0]   byte_cnt;
    logic [LANES-1:0]   lane_gate;
    logic [LANES-1:0]   tree_in;
    logic [CNT_W-1:0]   tree_sum;
    logic [FLD_V-1:0]   lanes_nx;
    logic [CNT_W-1:0]   count_q;
    logic [FLD_V-1:0]   lane_q;

    assign op = lcs_op_e'(op_sel);

    lcs_lane_array #(
        .LANES(LANES), .LANE_W(LANE_W), .FIELD_W(FIELD_W)
    ) i_lanes (
        .a_vec(vec_a), .b_vec(vec_b),
        .eq_hit(eq_hit), .le_hit(le_hit), .zero_hit(zero_hit),
        .byte_cnt(byte_cnt)
    );

    // Gate: the mask when gating is on, otherwise every lane is open.
    assign lane_gate = gate_en ? gate_mask : '1;

    // Choose the adder tree operand and the next per-lane vector for the op.
    always_comb begin
        tree_in  = '0;
        lanes_nx = '0;
        case (op)
            OP_POPM: tree_in  = gate_mask;
            OP_BYTE: lanes_nx = byte_cnt;
            OP_EQ:   tree_in  = eq_hit & lane_gate;
            OP_EQZ:  tree_in  = zero_hit & lane_gate;
            OP_LE:   tree_in  = le_hit & lane_gate;
            OP_LEZ:  tree_in  = zero_hit & lane_gate;
            default: ;
        endcase
    end

    lcs_popcount #(.N(LANES), .CW(CNT_W)) i_tree (
        .bits_i(tree_in), .total_o(tree_sum)
    );

    // Result register: capture on start, pulse valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            count_q <= '0;
            lane_q  <= '0;
        end else begin
            valid_o <= start;
            if (start) begin
                count_q <= tree_sum;
                lane_q  <= lanes_nx;
            end
        end
    end

    assign count_o    = {{(OUT_W-CNT_W){1'b0}}, count_q};
    assign lane_cnt_o = lane_q;

    // R1: a registered count never goes above the lane count.
    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_q <= CNT_W'(LANES)));

    // R8: valid follows start one cycle later and otherwise stays low.
    a_r8_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(rst_n)) |-> valid_o);
    a_r8_valid_only_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> !valid_o);
    a_r8_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(count_q) && $stable(lane_q)));

    // R9: a nonzero scalar count never comes with per-lane counts.
    a_r9_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> (lane_q == '0));

    // R3 and R4: an equal lane or a zero lane must also pass the le test.
    a_r3_eq_implies_le: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_hit & ~le_hit) == '0);
    a_r4_zero_implies_le: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit & ~le_hit) == '0);

    // R10: reset clears the strobe and the count.
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && count_q == '0 && lane_q == '0));

    // R2: each registered byte count field stays within the byte width.
    for (genvar g = 0; g < LANES; g++) begin : g_fld_chk
        a_r2_field_range: assert property (@(posedge clk) disable iff (!rst_n)
            lane_q[g*FIELD_W +: FIELD_W] <= FIELD_W'(LANE_W));
    end
endmodule

// File: tb/test_lane_count_scan.sv
// Bench: walks a table of operations with hand-worked expected counts,
// then runs directed tests for reset, a ramp of lane values, byte counts,
// gating and the pulse and hold timing.
module test_lane_count_scan;
    localparam int NV = 19;

    typedef struct packed {
        logic [3:0]   req;
        logic [2:0]   op;
        logic         gate;
        logic [511:0] a;
        logic [511:0] b;
        logic [63:0]  m;
        logic [6:0]   exp;
    } vec_t;

    // R1 popcount, R3 eq, R4 eqz, R5 le, R6 lez, R7 gating, R9 unused code
    localparam vec_t TBL [NV] = '{
        '{4'd1, 3'd0, 1'b0, {64{8'h00}}, {64{8'h00}}, 64'haaaa_aaaa_aaaa_aaaa, 7'd32},
        '{4'd1, 3'd0, 1'b0, {64{8'h00}}, {64{8'h00}}, 64'hffff_ffff_ffff_ffff, 7'd64},
        '{4'd1, 3'd0, 1'b0, {64{8'h11}}, {64{8'h22}}, 64'h0000_0000_0000_00aa, 7'd4},
        '{4'd1, 3'd0, 1'b0, {64{8'hff}}, {64{8'hff}}, 64'h0,                   7'd0},
        '{4'd7, 3'd0, 1'b1, {64{8'h00}}, {64{8'h00}}, 64'haaaa_aaaa_aaaa_aaaa, 7'd32},
        '{4'd3, 3'd2, 1'b0, {64{8'h05}}, {64{8'h05}}, 64'h0,                   7'd64},
        '{4'd3, 3'd2, 1'b0, {64{8'h05}}, {64{8'h06}}, 64'h0,                   7'd0},
        '{4'd4, 3'd3, 1'b0, {64{8'h00}}, {64{8'hff}}, 64'h0,                   7'd64},
        '{4'd4, 3'd3, 1'b0, {64{8'h01}}, {64{8'h00}}, 64'h0,                   7'd0},
        '{4'd5, 3'd4, 1'b0, {64{8'h05}}, {64{8'h06}}, 64'h0,                   7'd64},
        '{4'd5, 3'd4, 1'b0, {64{8'h06}}, {64{8'h05}}, 64'h0,                   7'd0},
        '{4'd5, 3'd4, 1'b0, {64{8'h80}}, {64{8'h7f}}, 64'h0,                   7'd0},
        '{4'd5, 3'd4, 1'b0, {64{8'h7f}}, {64{8'h80}}, 64'h0,                   7'd64},
        '{4'd6, 3'd5, 1'b0, {64{8'h00}}, {64{8'hff}}, 64'h0,                   7'd64},
        '{4'd6, 3'd5, 1'b0, {64{8'h01}}, {64{8'hff}}, 64'h0,                   7'd0},
        '{4'd7, 3'd2, 1'b1, {64{8'h33}}, {64{8'h33}}, 64'haaaa_aaaa_aaaa_aaaa, 7'd32},
        '{4'd7, 3'd4, 1'b1, {64{8'h01}}, {64{8'h02}}, 64'h0000_0000_0000_00ff, 7'd8},
        '{4'd7, 3'd3, 1'b0, {64{8'h00}}, {64{8'h00}}, 64'h0,                   7'd64},
        '{4'd9, 3'd6, 1'b0, {64{8'h05}}, {64{8'h05}}, 64'hffff_ffff_ffff_ffff, 7'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_sel = '0;
    logic          gate_en = 1'b0;
    logic [511:0]  vec_a = '0;
    logic [511:0]  vec_b = '0;
    logic [63:0]   gate_mask = '0;
    logic          valid_o;
    logic [31:0]   count_o;
    logic [255:0]  lane_cnt_o;

    int checks = 0;
    int errors = 0;
    logic [511:0] ramp;
    logic [31:0]  held;

    always #10 clk = ~clk;

    lane_count_scan i_lane_count_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .gate_en(gate_en), .vec_a(vec_a), .vec_b(vec_b),
        .gate_mask(gate_mask), .valid_o(valid_o), .count_o(count_o),
        .lane_cnt_o(lane_cnt_o)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Start one operation and return on the falling edge where the result is due.
    task automatic run(input logic [2:0] op, input logic g, input logic [511:0] a,
                       input logic [511:0] b, input logic [63:0] m);
        @(negedge clk);
        op_sel = op; gate_en = g; vec_a = a; vec_b = b; gate_mask = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 valid", 256'(valid_o), 256'(0));
        chk("R10 count", 256'(count_o), 256'(0));
        chk("R10 lanes", lane_cnt_o, 256'(0));
        rst_n = 1'b1;

        // Table walk; the lane vector must stay zero for these ops (R9)
        for (int i = 0; i < NV; i++) begin
            run(TBL[i].op, TBL[i].gate, TBL[i].a, TBL[i].b, TBL[i].m);
            chk($sformatf("R%0d count row %0d", TBL[i].req, i), 256'(count_o), 256'(TBL[i].exp));
            chk($sformatf("R9 lanes row %0d", i), lane_cnt_o, 256'(0));
            chk("R8 valid due", 256'(valid_o), 256'(1));
        end

        // Ramp of lane values: byte i = i; compare vector is all 31
        for (int i = 0; i < 64; i++) ramp[8*i +: 8] = 8'(i);
        run(3'd4, 1'b0, ramp, {64{8'd31}}, 64'h0);
        chk("R5 ramp le", 256'(count_o), 256'(32));
        run(3'd2, 1'b0, ramp, {64{8'd31}}, 64'h0);
        chk("R3 ramp eq", 256'(count_o), 256'(1));
        run(3'd3, 1'b0, ramp, {64{8'd31}}, 64'h0);
        chk("R4 ramp eqz", 256'(count_o), 256'(1));
        run(3'd5, 1'b0, ramp, {64{8'd31}}, 64'h0);
        chk("R6 ramp lez", 256'(count_o), 256'(1));
        run(3'd4, 1'b1, ramp, {64{8'd31}}, 64'hffff_ffff_0000_0000);
        chk("R7 ramp gate high", 256'(count_o), 256'(0));
        run(3'd4, 1'b1, ramp, {64{8'd31}}, 64'h0000_0000_0000_ffff);
        chk("R7 ramp gate low16", 256'(count_o), 256'(16));

        // R2: byte counts over the ramp; gate on with an empty mask has no effect (R7)
        run(3'd1, 1'b1, ramp, {64{8'hff}}, 64'h0);
        chk("R2 byte scalar", 256'(count_o), 256'(0));
        for (int i = 0; i < 64; i++)
            chk($sformatf("R2 lane %0d", i), 256'(lane_cnt_o[4*i +: 4]),
                256'($countones(8'(i))));
        run(3'd1, 1'b0, {64{8'hff}}, '0, 64'h0);
        chk("R2 byte full", lane_cnt_o, {64{4'h8}});

        // R8: valid pulse drops, results hold without start
        run(3'd0, 1'b0, '0, '0, 64'h0000_0000_0000_0f0f);
        chk("R1 popcount 0f0f", 256'(count_o), 256'(8));
        held = count_o;
        @(negedge clk);
        chk("R8 pulse drops", 256'(valid_o), 256'(0));
        gate_mask = '1; op_sel = 3'd0;
        repeat (2) @(negedge clk);
        chk("R8 count holds", 256'(count_o), 256'(held));

        // R10: reset in mid-run clears the results
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 count after reset", 256'(count_o), 256'(0));
        chk("R10 valid after reset", 256'(valid_o), 256'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule